// File: doc/BRIEF.md
# Smart Card Response Timeout Supervisor

This block watches the time a smart card takes to answer. Four monitors run side by side, and each one has its own start and stop events. The start monitor counts card clock cycles from the release of the card reset until the first start bit of the answer-to-reset arrives. The character monitor counts etu between the leading edges of successive received characters while the answer-to-reset is in progress. The duration monitor counts etu over the whole answer-to-reset stream. The block monitor counts etu from the last character sent to the card until the first character the card sends back.

Each monitor compares its count against its own programmable limit. A monitor that runs past its limit sets a sticky status bit, and that bit drives a maskable interrupt. All interrupts are ORed onto a single summary line. Only the start timeout acts by itself: it also issues a one-cycle deactivation request. The other three timeouts are left for software to handle. Bit sampling, parity checking and the warm-reset procedure are done by neighbouring logic, which supplies the strobes this block uses.

Top module: `scto_supervisor`

## Requirements
- R1: The start monitor is armed by `rst_release` and counts `clk_tick` pulses. A `rx_start` stops it. If the (`lim_start`+1)-th tick arrives while it is armed, `status[0]` is set.
- R2: In the same cycle that `status[0]` is set by a start timeout, `deact_req` is high for exactly one cycle.
- R3: While `atr_phase` is high, each `rx_start` restarts the character monitor's etu count. The (`lim_char`+1)-th etu with no new `rx_start` sets `status[1]`. An `atr_done` pulse, or `atr_phase` going low, stops the character monitor.
- R4: The duration monitor starts at the first `rx_start` of an answer-to-reset phase and counts etu. It sets `status[2]` on the (`lim_dur`+1)-th etu if that etu arrives before its window closes. It starts again only after `atr_phase` has been low.
- R5: The duration window closes once `atr_done` has been seen and 12 etu have passed since the most recent `rx_start`.
- R6: A `tx_start` while `atr_phase` is low arms or restarts the block monitor. A `rx_start` stops it. The (`lim_blk`+1)-th etu with no stop sets `status[3]`.
- R7: Each monitor raises its timeout at most once per arming. Further ticks without a new arming set nothing after the status bit has been cleared.
- R8: A status bit stays set until a 1 is written to the same bit of `status_clr`. If a set and a clear of the same bit occur in the same cycle, the set wins.
- R9: Each `irq[i]` equals `status[i]` AND `irq_mask[i]`, and `irq_any` is the OR of the four. Index order is 0 start, 1 character, 2 duration, 3 block.
- R10: A `deact` pulse stops every monitor, and no timeout follows from that arming.
- R11: After reset, `status`, `irq`, `irq_any` and `deact_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_tick | input | 1 | One pulse per card clock cycle |
| etu_tick | input | 1 | One pulse per elementary time unit |
| rst_release | input | 1 | Pulse when the card reset is de-asserted |
| rx_start | input | 1 | Leading edge of a received character's start bit |
| tx_start | input | 1 | Leading edge of a transmitted character's start bit |
| atr_phase | input | 1 | High while the answer-to-reset is being received |
| atr_done | input | 1 | Pulse when the answer-to-reset is judged complete |
| deact | input | 1 | Pulse when deactivation begins; stops all monitors |
| lim_start | input | CNT_W | Start timeout limit in card clock cycles |
| lim_char | input | CNT_W | Character gap limit in etu |
| lim_dur | input | CNT_W | Total answer-to-reset duration limit in etu |
| lim_blk | input | CNT_W | Block wait limit in etu |
| irq_mask | input | 4 | Per-timeout interrupt enable |
| status_clr | input | 4 | Write-one-to-clear strobe for status |
| status | output | 4 | Sticky timeout flags |
| irq | output | 4 | Masked per-timeout interrupts |
| irq_any | output | 1 | OR of all masked interrupts |
| deact_req | output | 1 | One-cycle deactivation request on start timeout |

## Verification
The block and character monitors are driven with random limits and random gaps. Their results are compared with a bench function that predicts a timeout exactly when the gap is longer than the limit, so an off-by-one in the counting is caught on either side. The duration monitor is tried with directed runs whose limits fall one etu on each side of the closing point. Those runs show whether the 12-etu tail after the last character is counted and whether the window stays open until `atr_done`. Further directed runs cover the start timeout with and without an early character, restart by repeated characters, masking, sticky clear, a second timeout that must not occur, and deactivation while the monitors are armed.

// File: rtl/scto_pkg.sv
// Shared definitions for the response timeout supervisor.
// Assumes: four monitors, indexed in the fixed order given here.
package scto_pkg;
    localparam int N_TO = 4;
    typedef enum logic [1:0] {
        TO_START = 2'd0,
        TO_CHAR  = 2'd1,
        TO_DUR   = 2'd2,
        TO_BLK   = 2'd3
    } to_idx_e;
endpackage

// File: rtl/scto_timer.sv
// One-shot response timer.
// Counts tick pulses after an arm event. It fires once when a tick arrives
// with the count already at or above the limit. A stop, an arm or a fire
// ends the run. Assumes the arm and stop strobes last a single cycle.
module scto_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             stop,
    input  logic [CNT_W-1:0] limit,
    output logic             fire,
    output logic             active
);
    logic [CNT_W-1:0] count_q;
    logic             active_q;

    // Timeout event: an armed timer, left alone this cycle, reaches its limit
    always_comb fire = active_q && tick && !stop && !arm && (count_q >= limit);

    // Run state and count; stop has priority over arm, and arm over counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            count_q  <= '0;
        end else if (stop) begin
            active_q <= 1'b0;
        end else if (arm) begin
            active_q <= 1'b1;
            count_q  <= '0;
        end else if (fire) begin
            active_q <= 1'b0;
        end else if (active_q && tick) begin
            count_q  <= count_q + 1'b1;
        end
    end

    assign active = active_q;

    // R7: a fire ends the arming; nothing fires again without a new arm
    a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!active_q && !fire));
endmodule

// File: rtl/scto_dur_mon.sv
// Answer-to-reset total duration monitor.
// Arms on the first character start of a phase and times the total in etu.
// A tail counter is reloaded at each character start. The window closes
// once the done pulse has been seen and the tail has run out. Assumes
// that abort is held high while no answer-to-reset phase is running.
module scto_dur_mon #(
    parameter int CNT_W    = 20,
    parameter int TAIL_ETU = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_evt,
    input  logic             done_evt,
    input  logic             abort,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    localparam int TAIL_W = $clog2(TAIL_ETU + 1);

    logic              used_q;
    logic              closing_q;
    logic [TAIL_W-1:0] tail_q;
    logic              active;
    logic              arm;
    logic              stop;

    // Arm only once per phase; end on abort or once the tail has closed
    always_comb begin
        arm  = start_evt && !active && !used_q && !abort;
        stop = abort || (closing_q && (tail_q == '0));
    end

    // Phase bookkeeping: used flag, closing flag and tail counter
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            used_q    <= 1'b0;
            closing_q <= 1'b0;
            tail_q    <= '0;
        end else begin
            if (arm)
                used_q <= 1'b1;
            if (start_evt && (active || arm))
                tail_q <= TAIL_W'(TAIL_ETU);
            else if (tick && (tail_q != '0))
                tail_q <= tail_q - 1'b1;
            if (arm)
                closing_q <= 1'b0;
            else if (done_evt && active)
                closing_q <= 1'b1;
        end
    end

    scto_timer #(.CNT_W(CNT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .arm   (arm),
        .stop  (stop),
        .limit (limit),
        .fire  (fire),
        .active(active)
    );

    // R5: an end without abort or fire happens only at a closed, drained window
    a_r5_close_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !$past(abort) && !$past(fire))
            |-> ($past(closing_q) && ($past(tail_q) == '0)));
endmodule

// File: rtl/scto_irq.sv
// Sticky status and interrupt combiner.
// Sets a status bit on each timeout event and clears it by write-one-to-clear.
// A set wins over a clear in the same cycle. Each bit is masked into its
// interrupt, and the interrupts are ORed into one summary line.
module scto_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic [N-1:0] irq,
    output logic         irq_any
);
    logic [N-1:0] status_q;

    // Per-bit sticky flag with set priority
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else if (set[i])
                status_q[i] <= 1'b1;
            else if (clr[i])
                status_q[i] <= 1'b0;
        end
    end

    // Output gating and summary line
    always_comb begin
        status  = status_q;
        irq     = status_q & mask;
        irq_any = |irq;
    end

    // R8: a set bit is lost only through its own clear strobe
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> ((($past(status_q) & ~$past(clr)) & ~status_q) == '0));
endmodule

// File: rtl/scto_supervisor.sv
// Smart card response timeout supervisor (top).
// Runs four monitors: start (card clocks), character gap, total duration
// and block wait (etu). Only a start timeout requests deactivation by
// itself. Assumes every strobe input is a single-cycle pulse on clk.
module scto_supervisor
    import scto_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int TAIL_ETU = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_tick,
    input  logic             etu_tick,
    input  logic             rst_release,
    input  logic             rx_start,
    input  logic             tx_start,
    input  logic             atr_phase,
    input  logic             atr_done,
    input  logic             deact,
    input  logic [CNT_W-1:0] lim_start,
    input  logic [CNT_W-1:0] lim_char,
    input  logic [CNT_W-1:0] lim_dur,
    input  logic [CNT_W-1:0] lim_blk,
    input  logic [N_TO-1:0]  irq_mask,
    input  logic [N_TO-1:0]  status_clr,
    output logic [N_TO-1:0]  status,
    output logic [N_TO-1:0]  irq,
    output logic             irq_any,
    output logic             deact_req
);
    logic [N_TO-1:0] fire;
    logic            start_act;
    logic            char_act;
    logic            blk_act;
    logic            deact_q;

    // Start monitor: reset release to first received start bit
    scto_timer #(.CNT_W(CNT_W)) u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (clk_tick),
        .arm   (rst_release),
        .stop  (rx_start || deact),
        .limit (lim_start),
        .fire  (fire[TO_START]),
        .active(start_act)
    );

    // Character monitor: gap between received characters during the phase
    scto_timer #(.CNT_W(CNT_W)) u_char (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (etu_tick),
        .arm   (rx_start && atr_phase),
        .stop  (deact || atr_done || !atr_phase),
        .limit (lim_char),
        .fire  (fire[TO_CHAR]),
        .active(char_act)
    );

    // Duration monitor: whole stream plus tail
    scto_dur_mon #(.CNT_W(CNT_W), .TAIL_ETU(TAIL_ETU)) u_dur (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (etu_tick),
        .start_evt(rx_start && atr_phase),
        .done_evt (atr_done),
        .abort    (deact || !atr_phase),
        .limit    (lim_dur),
        .fire     (fire[TO_DUR])
    );

    // Block monitor: last transmitted character to first reply character
    scto_timer #(.CNT_W(CNT_W)) u_blk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (etu_tick),
        .arm   (tx_start && !atr_phase),
        .stop  (rx_start || deact),
        .limit (lim_blk),
        .fire  (fire[TO_BLK]),
        .active(blk_act)
    );

    scto_irq #(.N(N_TO)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (fire),
        .clr    (status_clr),
        .mask   (irq_mask),
        .status (status),
        .irq    (irq),
        .irq_any(irq_any)
    );

    // Autonomous deactivation request, one cycle, on start timeout
    always_ff @(posedge clk) begin
        if (!rst_n)
            deact_q <= 1'b0;
        else
            deact_q <= fire[TO_START];
    end

    assign deact_req = deact_q;

    // R2: the request always comes with the start status flag
    a_r2_deact_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        deact_req |-> status[TO_START]);

    // R2: the request lasts a single cycle
    a_r2_deact_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        deact_req |=> !deact_req);

    // R10: a deactivation leaves no monitor of the start/char/block set running
    a_r10_deact_stops: assert property (@(posedge clk) disable iff (!rst_n)
        deact |=> (!start_act && !char_act && !blk_act));
endmodule

// File: tb/tb_scto_supervisor.sv
`timescale 1ns/1ps
module tb_scto_supervisor;
    localparam int CNT_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_tick = 1'b0, etu_tick = 1'b0, rst_release = 1'b0;
    logic             rx_start = 1'b0, tx_start = 1'b0, atr_phase = 1'b0;
    logic             atr_done = 1'b0, deact = 1'b0;
    logic [CNT_W-1:0] lim_start = '0, lim_char = '0, lim_dur = '0, lim_blk = '0;
    logic [3:0]       irq_mask = 4'hF, status_clr = 4'h0;
    logic [3:0]       status, irq;
    logic             irq_any, deact_req;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    scto_supervisor #(.CNT_W(CNT_W), .TAIL_ETU(12)) dut (
        .clk(clk), .rst_n(rst_n), .clk_tick(clk_tick), .etu_tick(etu_tick),
        .rst_release(rst_release), .rx_start(rx_start), .tx_start(tx_start),
        .atr_phase(atr_phase), .atr_done(atr_done), .deact(deact),
        .lim_start(lim_start), .lim_char(lim_char), .lim_dur(lim_dur),
        .lim_blk(lim_blk), .irq_mask(irq_mask), .status_clr(status_clr),
        .status(status), .irq(irq), .irq_any(irq_any), .deact_req(deact_req)
    );

    function automatic bit exp_fire(input int gap, input int lim);
        return gap > lim;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one strobe cycle: drive at a falling edge, release at the next falling edge
    task automatic step(input bit ck, input bit et, input bit rel, input bit rxs,
                        input bit txs, input bit dn, input bit dea);
        @(negedge clk);
        clk_tick = ck; etu_tick = et; rst_release = rel; rx_start = rxs;
        tx_start = txs; atr_done = dn; deact = dea;
        @(negedge clk);
        clk_tick = 0; etu_tick = 0; rst_release = 0; rx_start = 0;
        tx_start = 0; atr_done = 0; deact = 0;
    endtask

    task automatic etus(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic cclks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic clr_all();
        @(negedge clk); status_clr = 4'hF;
        @(negedge clk); status_clr = 4'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 status", {4'h0, status}, 8'h0);
        check("R11 irq", {3'h0, irq_any, irq}, 8'h0);
        check("R11 deact_req", {7'h0, deact_req}, 8'h0);

        // R1/R2 start timeout at limit+1 card clocks
        lim_start = 5;
        step(0, 0, 1, 0, 0, 0, 0);
        cclks(5);
        check("R1 no timeout at limit", {4'h0, status}, 8'h0);
        cclks(1);
        check("R1 timeout at limit+1", {4'h0, status}, 8'h1);
        check("R2 deact_req pulse", {7'h0, deact_req}, 8'h1);
        check("R9 irq_any", {7'h0, irq_any}, 8'h1);
        step(0, 0, 0, 0, 0, 0, 0);
        check("R2 deact_req one cycle", {7'h0, deact_req}, 8'h0);
        check("R8 sticky", {4'h0, status}, 8'h1);
        clr_all();
        cclks(10);
        check("R7 no second timeout", {4'h0, status}, 8'h0);

        // R9 masking
        step(0, 0, 1, 0, 0, 0, 0);
        irq_mask = 4'hE;
        cclks(6);
        check("R9 masked irq", {3'h0, irq_any, irq}, 8'h0);
        check("R9 status still set", {4'h0, status}, 8'h1);
        irq_mask = 4'hF;
        @(negedge clk);
        check("R9 unmasked irq", {3'h0, irq_any, irq}, 8'h11);
        clr_all();

        // R1 stop by early start bit
        step(0, 0, 1, 0, 0, 0, 0);
        cclks(3);
        step(0, 0, 0, 1, 0, 0, 0);
        cclks(10);
        check("R1 start bit stops monitor", {4'h0, status}, 8'h0);

        // R10 deactivation stops start and block monitors
        lim_blk = 4;
        step(0, 0, 1, 0, 1, 0, 0);
        cclks(2); etus(2);
        step(0, 0, 0, 0, 0, 0, 1);
        cclks(10); etus(10);
        check("R10 deact stops monitors", {4'h0, status}, 8'h0);
        check("R10 no deact_req", {7'h0, deact_req}, 8'h0);

        // R3 character gap with restart
        lim_char = 4; lim_dur = 1000;
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(3);
        step(0, 0, 0, 1, 0, 0, 0);
        etus(4);
        check("R3 restart, no timeout at limit", {4'h0, status}, 8'h0);
        etus(1);
        check("R3 timeout at limit+1", {4'h0, status}, 8'h2);
        atr_phase = 0; clr_all();

        // R3 stopped by done
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(2);
        step(0, 0, 0, 0, 0, 1, 0);
        etus(10);
        check("R3 done stops gap monitor", {4'h0, status[1]}, 8'h0);
        atr_phase = 0; clr_all();

        // R4 duration timeout at limit+1 with second character
        lim_char = 1000; lim_dur = 20;
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(10);
        step(0, 0, 0, 1, 0, 1, 0);
        etus(10);
        check("R4 no timeout at limit", {4'h0, status}, 8'h0);
        etus(1);
        check("R4 timeout at limit+1", {4'h0, status}, 8'h4);
        atr_phase = 0; clr_all();

        // R5 tail: window closes 12 etu after last start
        lim_dur = 21;
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(10);
        step(0, 0, 0, 1, 0, 1, 0);
        etus(12);
        check("R5 timeout inside tail", {4'h0, status}, 8'h4);
        atr_phase = 0; clr_all();
        lim_dur = 22;
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(10);
        step(0, 0, 0, 1, 0, 1, 0);
        etus(30);
        check("R5 window closed after tail", {4'h0, status}, 8'h0);
        atr_phase = 0; clr_all();

        // R5 window stays open until done
        lim_dur = 15;
        atr_phase = 1;
        step(0, 0, 0, 1, 0, 0, 0);
        etus(16);
        check("R5 open without done", {4'h0, status}, 8'h4);
        atr_phase = 0; clr_all();

        // R6 block monitor, random gaps
        for (int it = 0; it < 20; it++) begin
            int lim, gap;
            lim = 3 + int'($urandom % 18);
            gap = int'($urandom % 26);
            lim_blk = CNT_W'(lim);
            step(0, 0, 0, 0, 1, 0, 0);
            etus(gap);
            step(0, 0, 0, 1, 0, 0, 0);
            check("R6 block timeout", {4'h0, status},
                  {4'h0, exp_fire(gap, lim), 3'b000});
            clr_all();
        end

        // R6 restart on a later transmitted character
        lim_blk = 5;
        step(0, 0, 0, 0, 1, 0, 0);
        etus(4);
        step(0, 0, 0, 0, 1, 0, 0);
        etus(5);
        check("R6 restart by tx", {4'h0, status}, 8'h0);
        etus(1);
        check("R6 timeout after restart", {4'h0, status}, 8'h8);
        clr_all();

        // R3 character monitor, random gaps
        lim_dur = 100000;
        for (int it = 0; it < 15; it++) begin
            int lim, gap;
            lim = 2 + int'($urandom % 15);
            gap = int'($urandom % 20);
            lim_char = CNT_W'(lim);
            atr_phase = 1;
            step(0, 0, 0, 1, 0, 0, 0);
            etus(gap);
            step(0, 0, 0, 1, 0, 0, 0);
            check("R3 random gap", {4'h0, status},
                  {6'h0, exp_fire(gap, lim), 1'b0});
            atr_phase = 0;
            clr_all();
        end

        // R8 set wins over simultaneous clear
        lim_blk = 2;
        step(0, 0, 0, 0, 1, 0, 0);
        etus(2);
        @(negedge clk); etu_tick = 1; status_clr = 4'h8;
        @(negedge clk); etu_tick = 0; status_clr = 4'h0;
        check("R8 set beats clear", {4'h0, status}, 8'h8);
        clr_all();
        check("R8 clear", {4'h0, status}, 8'h0);

        report();
    end
endmodule